// File: doc/BRIEF.md
# Prioritised Level-Sensitive Interrupt Controller

This block collects twenty level-sensitive interrupt requests, passes each through a synchroniser and then combines them with two independent sets of enable bits. One set drives the normal interrupt line (`irq_o`). The other set drives the fast interrupt line (`fiq_o`). Software never writes an enable word directly. Each enable set has a write-one-to-set port and a write-one-to-clear port, so each driver can change its own bits without a read-modify-write.

A fixed-priority encoder looks at the enabled pending requests. It reports the winner as its bit index plus one, or zero when none is pending. The order is irregular by design: memory parity first and the four PCI error conditions last. A handler acknowledges a source by masking it through the clear port. A source that is still asserted shows up again as soon as it is unmasked.

Access goes through a small register bus: a 3-bit word address, single-cycle write and read strobes, and a read-data register. Bus words are as wide as the source vector.

Top module: `pic_ctrl`

## Requirements
- R1: During and after a synchronous active-low reset, both enable sets are all zero, `irq_o` and `fiq_o` are low, and `irq_code_o` is 0.
- R2: A write to address 1 sets each IRQ enable bit whose data bit is one. Bits written as zero keep their value.
- R3: A write to address 2 clears each IRQ enable bit whose data bit is one. Bits written as zero keep their value. Writing all ones masks every source.
- R4: Addresses 4 (set) and 5 (clear) work the same way on a separate FIQ enable set. `fiq_o` is high exactly when some FIQ-enabled source is pending. Address 3 reads the pending sources ANDed with the FIQ enables. The IRQ and FIQ sets do not affect each other.
- R5: A read of address 0 returns the synchronised source vector ANDed with the IRQ enables. Bit n is source n.
- R6: `irq_code_o` and a read of address 6 give the index plus one of the highest-priority bit in the address-0 status, or 0 if that status is empty. The priority runs from highest to lowest by bit index: 13, 0, 10, 11, 5, 6, 7, 8, 12, 9, 14, 2, 3, 4, 1, 15, 16, 17, 18, 19.
- R7: `irq_o` is high exactly when the address-0 status is non-zero.
- R8: Sources are level sensitive. Masking a source that is still asserted removes it from status and the outputs. Unmasking it brings it back. It stays pending until its input drops.
- R9: A change on `src_i` reaches the status and outputs after the second rising edge that samples it, and not after the first.
- R10: `bus_rdata` loads on the edge where `bus_rd` is high and holds otherwise. Reads of addresses 1, 2, 4, 5 and 7 return 0. Writes to addresses 0, 3, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 20 | Asynchronous level-sensitive requests, bit n is source n |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 20 | Write data |
| bus_rdata | output | 20 | Registered read data |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| irq_code_o | output | 5 | Highest-priority enabled pending source plus one, 0 if none |

## Verification
- **Source changes:** a change on a source input shows on `irq_o`, `fiq_o` and `irq_code_o` after two rising edges. The bench therefore changes sources on a falling edge and checks on the falling edge after the second rise. The latency test also checks after the first rise, to prove nothing has moved yet.
- **Enable writes:** an enable write takes effect on the rise that samples the strobe. The outputs are checked on the next falling edge.
- **Reads:** a read returns data one edge after the strobe. The bench samples `bus_rdata` on the falling edge after that rise.

// File: rtl/pic_pkg.sv
// Package: shared sizes, register addresses and the fixed priority order
// of the interrupt controller. Assumes exactly twenty sources.
package pic_pkg;
    localparam int SRC_N  = 20;
    localparam int CODE_W = $clog2(SRC_N + 1);
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_IRQ_STAT = 3'd0,
        A_IRQ_SET  = 3'd1,
        A_IRQ_CLR  = 3'd2,
        A_FIQ_STAT = 3'd3,
        A_FIQ_SET  = 3'd4,
        A_FIQ_CLR  = 3'd5,
        A_CODE     = 3'd6,
        A_SPARE    = 3'd7
    } pic_addr_e;

    // Source bit index at a given priority rank (rank 0 wins).
    function automatic int rank_src(input int rank);
        case (rank)
            0:  return 13;
            1:  return 0;
            2:  return 10;
            3:  return 11;
            4:  return 5;
            5:  return 6;
            6:  return 7;
            7:  return 8;
            8:  return 12;
            9:  return 9;
            10: return 14;
            11: return 2;
            12: return 3;
            13: return 4;
            14: return 1;
            default: return rank;
        endcase
    endfunction
endpackage

// File: rtl/pic_sync.sv
// Multi-stage synchroniser for a vector of asynchronous level inputs.
// Assumes the inputs are slow levels, so per-bit skew is acceptable.
module pic_sync #(
    parameter int WIDTH  = 20,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage samples the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-samples the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];

    // R9: one stage after a reset-free edge, the output follows the previous last-but-one stage
    a_r9_chain: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> dout == $past(STAGES > 1 ? stg[STAGES-2] : din));
endmodule

// File: rtl/pic_mask_reg.sv
// Enable register changed only through write-one-to-set and
// write-one-to-clear strobes. Assumes the two strobes never coincide.
module pic_mask_reg #(
    parameter int WIDTH = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] bits,
    output logic [WIDTH-1:0] en_q
);
    // Update enables: OR in set bits, or AND out clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (set_we) en_q <= en_q | bits;
        else if (clr_we) en_q <= en_q & ~bits;
    end

    // R1: reset leaves every enable low
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> en_q == '0);
    // R2: every written one is set afterwards, zeros keep their value
    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((en_q & $past(bits)) == $past(bits)) &&
                   ((en_q & ~$past(bits)) == ($past(en_q) & ~$past(bits))));
    // R3: every written one is cleared afterwards, zeros keep their value
    a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((en_q & $past(bits)) == '0) &&
                   ((en_q & ~$past(bits)) == ($past(en_q) & ~$past(bits))));
endmodule

// File: rtl/pic_prio_enc.sv
// Fixed-priority encoder over the enabled pending sources, ranked by
// pic_pkg::rank_src. Output is index plus one, or zero when idle.
module pic_prio_enc
    import pic_pkg::*;
(
    input  logic [SRC_N-1:0]  req,
    output logic [CODE_W-1:0] code
);
    // Scan from lowest to highest rank so the best match is written last.
    always_comb begin
        code = '0;
        for (int r = SRC_N - 1; r >= 0; r--) begin
            if (req[rank_src(r)]) code = CODE_W'(rank_src(r) + 1);
        end
    end
endmodule

// File: rtl/pic_ctrl.sv
// Level interrupt controller top: synchronises the sources, holds IRQ
// and FIQ enable sets, encodes the winning source and serves a small
// register bus. Assumes one bus strobe per cycle at most.
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [SRC_N-1:0]  bus_wdata,
    output logic [SRC_N-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              fiq_o,
    output logic [CODE_W-1:0] irq_code_o
);
    logic [SRC_N-1:0] pend;
    logic [SRC_N-1:0] irq_en;
    logic [SRC_N-1:0] fiq_en;
    logic [SRC_N-1:0] irq_stat;
    logic [SRC_N-1:0] fiq_stat;
    logic [CODE_W-1:0] code;
    pic_addr_e        addr;

    assign addr = pic_addr_e'(bus_addr);

    pic_sync #(.WIDTH(SRC_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(src_i), .dout(pend)
    );

    pic_mask_reg #(.WIDTH(SRC_N)) u_irq_en (
        .clk(clk), .rst_n(rst_n),
        .set_we(bus_wr && addr == A_IRQ_SET),
        .clr_we(bus_wr && addr == A_IRQ_CLR),
        .bits(bus_wdata), .en_q(irq_en)
    );

    pic_mask_reg #(.WIDTH(SRC_N)) u_fiq_en (
        .clk(clk), .rst_n(rst_n),
        .set_we(bus_wr && addr == A_FIQ_SET),
        .clr_we(bus_wr && addr == A_FIQ_CLR),
        .bits(bus_wdata), .en_q(fiq_en)
    );

    pic_prio_enc u_enc (.req(irq_stat), .code(code));

    // Combine pending levels with each enable set.
    always_comb begin
        irq_stat = pend & irq_en;
        fiq_stat = pend & fiq_en;
    end

    assign irq_o      = |irq_stat;
    assign fiq_o      = |fiq_stat;
    assign irq_code_o = code;

    // Capture read data on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (addr)
                A_IRQ_STAT: bus_rdata <= irq_stat;
                A_FIQ_STAT: bus_rdata <= fiq_stat;
                A_CODE:     bus_rdata <= {{(SRC_N-CODE_W){1'b0}}, code};
                default:    bus_rdata <= '0;
            endcase
        end
    end

    // R7: the line and the encoder agree on whether anything is pending
    a_r7_line_code: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (irq_code_o != '0));
    // R6: a reported code names a source that is enabled and pending
    a_r6_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_code_o != '0) |-> (pend[irq_code_o - 1'b1] && irq_en[irq_code_o - 1'b1]));
    // R10: read data only moves on a read strobe
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && rst_n) |=> $stable(bus_rdata));
    // R4: the fast line never fires without a fast-enabled source
    a_r4_fiq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> (fiq_en != '0));
endmodule

// File: tb/pic_ctrl_test.sv
module pic_ctrl_test;
    import pic_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic              clk = 0;
    logic              rst_n = 0;
    logic [SRC_N-1:0]  src_i = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 0;
    logic              bus_rd = 0;
    logic [SRC_N-1:0]  bus_wdata = '0;
    logic [SRC_N-1:0]  bus_rdata;
    logic              irq_o, fiq_o;
    logic [CODE_W-1:0] irq_code_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int prio [SRC_N] = '{13, 0, 10, 11, 5, 6, 7, 8, 12, 9, 14, 2, 3, 4, 1, 15, 16, 17, 18, 19};

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o),
        .irq_code_o(irq_code_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [SRC_N-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        v = int'(bus_rdata);
    endtask

    task automatic drive_src(input logic [SRC_N-1:0] s);
        @(negedge clk);
        src_i = s;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        chk("R1 irq_o", irq_o, 0);
        chk("R1 fiq_o", fiq_o, 0);
        chk("R1 code", irq_code_o, 0);
        drive_src('1);
        chk("R1 irq after reset with sources high", irq_o, 0);
        rd(3'd0, v);
        chk("R1 status empty", v, 0);
        drive_src('0);
    endtask

    task automatic t_set_clear();
        int v;
        drive_src('1);
        wr(3'd1, 20'h00F0F);
        rd(3'd0, v);
        chk("R2 first set", v, 'h00F0F);
        wr(3'd1, 20'h30000);
        rd(3'd0, v);
        chk("R2 zeros keep value", v, 'h30F0F);
        wr(3'd2, 20'h00F00);
        rd(3'd0, v);
        chk("R3 partial clear", v, 'h3000F);
        wr(3'd2, '1);
        rd(3'd0, v);
        chk("R3 clear all", v, 0);
        chk("R3 irq masked", irq_o, 0);
        drive_src('0);
    endtask

    task automatic t_status_irq();
        int v;
        wr(3'd1, 20'h0A5A5);
        drive_src(20'h0FF00);
        rd(3'd0, v);
        chk("R5 status is pending AND enable", v, 'h0A500);
        chk("R7 irq high", irq_o, 1);
        drive_src(20'h0005A);
        chk("R7 irq low with only disabled sources", irq_o, 0);
        wr(3'd2, '1);
        drive_src('0);
    endtask

    task automatic t_priority();
        int v;
        wr(3'd1, '1);
        drive_src('1);
        for (int r = 0; r < SRC_N; r++) begin
            chk($sformatf("R6 code port rank %0d", r), irq_code_o, prio[r] + 1);
            rd(3'd6, v);
            chk($sformatf("R6 code read rank %0d", r), v, prio[r] + 1);
            drive_src(src_i & ~(20'(1) << prio[r]));
        end
        chk("R6 code idle", irq_code_o, 0);
        chk("R7 irq idle", irq_o, 0);
        wr(3'd2, '1);
    endtask

    task automatic t_fiq();
        int v;
        wr(3'd4, 20'h00004);
        drive_src(20'h00004);
        chk("R4 fiq high", fiq_o, 1);
        chk("R4 irq unaffected", irq_o, 0);
        rd(3'd3, v);
        chk("R4 fiq status", v, 'h4);
        wr(3'd1, 20'h00004);
        wr(3'd5, 20'h00004);
        chk("R4 fiq cleared", fiq_o, 0);
        chk("R4 irq set kept", irq_o, 1);
        wr(3'd2, '1);
        drive_src('0);
    endtask

    task automatic t_level();
        wr(3'd1, 20'h00020);
        drive_src(20'h00020);
        chk("R8 pending", irq_o, 1);
        wr(3'd2, 20'h00020);
        chk("R8 masked while asserted", irq_o, 0);
        wr(3'd1, 20'h00020);
        chk("R8 unmask returns", irq_o, 1);
        chk("R8 code after unmask", irq_code_o, 6);
        drive_src('0);
        chk("R8 drops with input", irq_o, 0);
        wr(3'd2, '1);
    endtask

    task automatic t_latency();
        wr(3'd1, 20'h00008);
        @(negedge clk);
        src_i = 20'h00008;
        @(negedge clk);
        chk("R9 not after one edge", irq_o, 0);
        @(negedge clk);
        chk("R9 after two edges", irq_o, 1);
        src_i = '0;
        @(negedge clk);
        chk("R9 still high one edge after drop", irq_o, 1);
        @(negedge clk);
        chk("R9 low two edges after drop", irq_o, 0);
        wr(3'd2, '1);
    endtask

    task automatic t_bus_misc();
        int v;
        drive_src('1);
        wr(3'd0, '1);
        wr(3'd3, '1);
        wr(3'd6, '1);
        wr(3'd7, '1);
        chk("R10 status write ignored irq", irq_o, 0);
        chk("R10 status write ignored fiq", fiq_o, 0);
        wr(3'd1, 20'h00001);
        rd(3'd1, v);
        chk("R10 set port reads zero", v, 0);
        rd(3'd7, v);
        chk("R10 spare reads zero", v, 0);
        rd(3'd0, v);
        @(negedge clk);
        chk("R10 rdata holds", int'(bus_rdata), 'h1);
        wr(3'd2, '1);
        drive_src('0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_status_irq();
        t_priority();
        t_fiq();
        t_level();
        t_latency();
        t_bus_misc();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule